// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a 32-pin general-purpose I/O bank. Software programs it through a plain 32-bit register bus: byte address, write strobe, write data and combinational read data. Each pin has a direction bit and an output bit. Neither register is written directly. Software writes a mask to a "set" alias or to a "clear" alias, so one pin can be changed without a read-modify-write sequence. The pin inputs pass through a two-stage synchroniser before any logic uses them. The bank drives `pad_out` and `pad_oe` to the pad ring.

The eight lowest pins can raise interrupts. A single 32-bit control word holds four byte-wide fields: rise enables, fall enables, debounce enables and level-mode selects. The word also changes only through set and clear aliases. In edge mode, the rise and fall bits pick the edges that latch a pending bit. In level mode, the same two bits pick active-high or active-low triggering. Pending bits are latched, can be read back, and are cleared by writing ones. Their OR drives the single `irq_o` line.

The bus has no back-pressure. Every access completes in the cycle it is presented: writes take effect at the next clock edge and reads return data in the same cycle. A streaming handshake therefore does not apply.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all pins are inputs (`pad_oe` = 0), and the output, interrupt-control and pending registers are all zero with `irq_o` low.
- R2: Writing to offset 0x04 sets the direction bits where the write data is one (those pins become outputs). Writing to 0x08 clears them. Zero bits leave a pin unchanged. Offset 0x00 reads the direction register and `pad_oe` follows it.
- R3: Writing to offset 0x10 sets output bits where the data is one, and writing to 0x14 clears them. Zero bits have no effect. `pad_out` follows the register and offset 0x10 reads it back.
- R4: Offset 0x0C reads, for each pin, the output register bit when the pin is an output and the synchronised input when it is an input. An input change is visible there two clock edges after it is applied.
- R5: The interrupt-control word has rise enables at bits 7:0, fall enables at 15:8, debounce enables at 23:16 and level selects at 31:24. Ones written to 0x18 set its bits and ones written to 0x1C clear them. Offset 0x18 reads it back. The debounce bits alone never cause a pending bit.
- R6: In edge mode (level bit 0), the rise bit latches pending on a low-to-high input change and the fall bit on a high-to-low change. With both bits set, either change latches pending. The pending bit and `irq_o` appear on the third clock edge after the pin changes.
- R7: An edge-mode pending bit stays set until a one is written to its position at offset 0x20.
- R8: In level mode (level bit 1), the rise bit makes a high input pending and the fall bit makes a low input pending. While the active level persists, a clear at 0x20 leaves the bit set.
- R9: Offset 0x24 reads the pending bits in bits 7:0. Bits 31:8 always read zero, and pins 8 to 31 never latch pending.
- R10: `irq_o` is high exactly when at least one pending bit is set.
- R11: If a detection and a clear write hit the same pending bit on the same edge, the bit ends up set.
- R12: A pin whose rise and fall enables are both zero latches no new pending bit, whatever its mode and input activity.
- R13: Reads of unmapped offsets return zero, and writes to read-only offsets (0x00, 0x0C, 0x24) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, acts at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pin inputs |
| pad_out | output | 32 | Output register driven toward the pads |
| pad_oe | output | 32 | Direction register, 1 = pin drives |
| irq_o | output | 1 | OR of the pending bits |

## Verification
A corrupted direction or output bit shows up on `pad_oe` or `pad_out` at the edge after the write that caused it, and in the 0x0C readback. A fault in the synchroniser or the previous-sample flop moves or drops the pending bit. This is visible at offset 0x24 and on `irq_o`, three edges after a pin change. Errors in the clear logic show up as a pending bit that should have been removed but survives one cycle after a 0x20 write, or one that vanishes when it should not. The bench samples every one of these points at the exact cycle where the change is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IRQ_PINS = 8;

  // register offsets (byte addresses)
  localparam logic [7:0] OFS_DIR_RD  = 8'h00;
  localparam logic [7:0] OFS_DIR_SET = 8'h04;
  localparam logic [7:0] OFS_DIR_CLR = 8'h08;
  localparam logic [7:0] OFS_PIN_RD  = 8'h0C;
  localparam logic [7:0] OFS_OUT_SET = 8'h10;
  localparam logic [7:0] OFS_OUT_CLR = 8'h14;
  localparam logic [7:0] OFS_ICF_SET = 8'h18;
  localparam logic [7:0] OFS_ICF_CLR = 8'h1C;
  localparam logic [7:0] OFS_PND_CLR = 8'h20;
  localparam logic [7:0] OFS_PND_RD  = 8'h24;

  // interrupt-control word; the most significant field comes first
  typedef struct packed {
    logic [IRQ_PINS-1:0] lvl;
    logic [IRQ_PINS-1:0] dbnc;
    logic [IRQ_PINS-1:0] fall;
    logic [IRQ_PINS-1:0] rise;
  } irq_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output irq_cfg_t          cfg_q
);
  logic hit_dir_set, hit_dir_clr, hit_out_set, hit_out_clr, hit_cfg_set, hit_cfg_clr;

  assign hit_dir_set = bus_we && (bus_addr == ADDR_W'(OFS_DIR_SET));
  assign hit_dir_clr = bus_we && (bus_addr == ADDR_W'(OFS_DIR_CLR));
  assign hit_out_set = bus_we && (bus_addr == ADDR_W'(OFS_OUT_SET));
  assign hit_out_clr = bus_we && (bus_addr == ADDR_W'(OFS_OUT_CLR));
  assign hit_cfg_set = bus_we && (bus_addr == ADDR_W'(OFS_ICF_SET));
  assign hit_cfg_clr = bus_we && (bus_addr == ADDR_W'(OFS_ICF_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      cfg_q <= '0;
    end else begin
      if (hit_dir_set) dir_q <= dir_q | bus_wdata;
      if (hit_dir_clr) dir_q <= dir_q & ~bus_wdata;
      if (hit_out_set) out_q <= out_q | bus_wdata;
      if (hit_out_clr) out_q <= out_q & ~bus_wdata;
      if (hit_cfg_set) cfg_q <= cfg_q | irq_cfg_t'(bus_wdata[$bits(irq_cfg_t)-1:0]);
      if (hit_cfg_clr) cfg_q <= cfg_q & ~irq_cfg_t'(bus_wdata[$bits(irq_cfg_t)-1:0]);
    end
  end

  a_r2_dir_set_acts: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dir_set |=> ((dir_q & $past(bus_wdata)) == $past(bus_wdata)));
  a_r2_dir_clr_acts: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dir_clr |=> ((dir_q & $past(bus_wdata)) == '0));
  a_r3_out_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(out_q));
  a_r5_cfg_clr_acts: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cfg_clr |=> ((cfg_q & $past(bus_wdata)) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] lvl_sel,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend_q,
  output logic         irq_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] det;
  logic [N-1:0] clr_eff;

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign det[i] = lvl_sel[i]
      ? ((rise_en[i] & pin_s[i]) | (fall_en[i] & ~pin_s[i]))
      : ((rise_en[i] & pin_s[i] & ~prev_q[i]) | (fall_en[i] & ~pin_s[i] & prev_q[i]));
  end

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pin_s;
      pend_q <= (pend_q & ~clr_eff) | det;
    end
  end

  assign irq_o = |pend_q;

  a_r7_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff == '0) |=> ((($past(pend_q)) & ~pend_q) == '0));
  a_r11_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (det != '0) |=> ((pend_q & $past(det)) == $past(det)));
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (((rise_en | fall_en) == '0) && (pend_q == '0)) |=> (pend_q == '0));
  a_r6_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_sel == '0) && (pin_s == prev_q) && (pend_q == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  output logic              irq_o
);
  logic [DATA_W-1:0]   pin_s;
  logic [DATA_W-1:0]   dir_q, out_q;
  irq_cfg_t            cfg_q;
  logic [IRQ_PINS-1:0] pend_q;
  logic                pnd_clr_we;

  gpio_sync #(.W(DATA_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pin_s)
  );

  gpio_regs #(.W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q), .cfg_q(cfg_q)
  );

  assign pnd_clr_we = bus_we && (bus_addr == ADDR_W'(OFS_PND_CLR));

  gpio_irq_unit #(.N(IRQ_PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s[IRQ_PINS-1:0]),
    .rise_en(cfg_q.rise), .fall_en(cfg_q.fall), .lvl_sel(cfg_q.lvl),
    .clr_we(pnd_clr_we), .clr_mask(bus_wdata[IRQ_PINS-1:0]),
    .pend_q(pend_q), .irq_o(irq_o)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_DIR_RD):  bus_rdata = dir_q;
      ADDR_W'(OFS_PIN_RD):  bus_rdata = (dir_q & out_q) | (~dir_q & pin_s);
      ADDR_W'(OFS_OUT_SET): bus_rdata = out_q;
      ADDR_W'(OFS_ICF_SET): bus_rdata = cfg_q;
      ADDR_W'(OFS_PND_RD):  bus_rdata = {{(DATA_W-IRQ_PINS){1'b0}}, pend_q};
      default:              bus_rdata = '0;
    endcase
  end

  a_r10_irq_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (pend_q != '0));
  a_r1_irq_low_on_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    rd(8'h00, rv); chk("R1 dir", rv, 0);
    rd(8'h10, rv); chk("R1 out", rv, 0);
    rd(8'h18, rv); chk("R1 cfg", rv, 0);
    rd(8'h24, rv); chk("R1 pend", rv, 0);
    chk("R1 oe/irq", {pad_oe[30:0], irq_o}, 0);
  endtask

  task automatic t_dir;
    wr(8'h04, 32'h0000_FF0F);
    rd(8'h00, rv); chk("R2 set", rv, 32'h0000_FF0F);
    wr(8'h08, 32'h0000_0F03);
    rd(8'h00, rv); chk("R2 clr", rv, 32'h0000_F00C);
    wr(8'h04, 32'h0);
    chk("R2 zero write / pad_oe", pad_oe, 32'h0000_F00C);
  endtask

  task automatic t_out;
    wr(8'h10, 32'h1234_5678);
    chk("R3 set pad_out", pad_out, 32'h1234_5678);
    wr(8'h14, 32'h0000_0070);
    rd(8'h10, rv); chk("R3 clr readback", rv, 32'h1234_5608);
  endtask

  task automatic t_pinval;
    logic [31:0] exp;
    pad_in = 32'hA5A5_5A5A;
    tick(1);
    rd(8'h0C, rv); chk("R4 not yet synced", rv, (32'h0000_F00C & 32'h1234_5608));
    tick(1);
    exp = (32'h0000_F00C & 32'h1234_5608) | (~32'h0000_F00C & 32'hA5A5_5A5A);
    rd(8'h0C, rv); chk("R4 mixed readback", rv, exp);
    pad_in = '0;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    tick(3);
  endtask

  task automatic t_cfg;
    wr(8'h18, 32'h00FF_0000);
    rd(8'h18, rv); chk("R5 set", rv, 32'h00FF_0000);
    wr(8'h1C, 32'h0055_0000);
    rd(8'h18, rv); chk("R5 clr", rv, 32'h00AA_0000);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_rise_sticky;
    wr(8'h18, 32'h0000_0001);
    pad_in[0] = 1'b1;
    tick(2);
    chk("R6 latency not early", {31'b0, irq_o}, 0);
    tick(1);
    chk("R6 R10 irq on rise", {31'b0, irq_o}, 1);
    rd(8'h24, rv); chk("R6 pend rise", rv, 32'h1);
    pad_in[0] = 1'b0;
    tick(5);
    rd(8'h24, rv); chk("R7 sticky", rv, 32'h1);
    wr(8'h20, 32'h1);
    rd(8'h24, rv); chk("R7 cleared", rv, 0);
    chk("R10 irq low", {31'b0, irq_o}, 0);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_both_fall;
    wr(8'h18, 32'h0000_0404);
    pad_in[2] = 1'b1; tick(3);
    rd(8'h24, rv); chk("R6 both rise", rv, 32'h4);
    wr(8'h20, 32'h4);
    pad_in[2] = 1'b0; tick(3);
    rd(8'h24, rv); chk("R6 both fall", rv, 32'h4);
    wr(8'h20, 32'h4);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_0800);
    pad_in[3] = 1'b1; tick(3);
    rd(8'h24, rv); chk("R6 fall-only ignores rise", rv, 0);
    pad_in[3] = 1'b0; tick(3);
    rd(8'h24, rv); chk("R6 fall-only", rv, 32'h8);
    wr(8'h20, 32'h8);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    wr(8'h18, 32'h0200_0002);
    pad_in[1] = 1'b1; tick(3);
    rd(8'h24, rv); chk("R8 high level", rv, 32'h2);
    wr(8'h20, 32'h2);
    rd(8'h24, rv); chk("R8 re-set while high", rv, 32'h2);
    pad_in[1] = 1'b0; tick(2);
    wr(8'h20, 32'h2);
    rd(8'h24, rv); chk("R8 clear after release", rv, 0);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h18, 32'h1000_1000);
    tick(1);
    rd(8'h24, rv); chk("R8 low level", rv, 32'h10);
    wr(8'h1C, 32'h0000_1000);
    wr(8'h20, 32'h10);
    rd(8'h24, rv); chk("R12 level masked", rv, 0);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask;
    wr(8'h18, 32'h0000_0020);
    wr(8'h1C, 32'h0000_2020);
    pad_in[5] = 1'b1; tick(3);
    rd(8'h24, rv); chk("R12 edge masked", rv, 0);
    wr(8'h18, 32'h0040_0000);
    pad_in[6] = 1'b1; tick(3);
    rd(8'h24, rv); chk("R5 debounce alone inert", rv, 0);
    pad_in[6:5] = 2'b00; tick(3);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_upper;
    wr(8'h18, 32'h0000_00FF);
    pad_in[31:8] = '1; tick(3);
    rd(8'h24, rv); chk("R9 upper pins silent", rv, 0);
    chk("R9 irq low", {31'b0, irq_o}, 0);
    pad_in[31:8] = '0; tick(3);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_race;
    wr(8'h18, 32'h0000_0080);
    pad_in[7] = 1'b1;
    tick(2);
    wr(8'h20, 32'h80);
    rd(8'h24, rv); chk("R11 detect beats clear", rv, 32'h80);
    wr(8'h20, 32'h80);
    rd(8'h24, rv); chk("R7 later clear", rv, 0);
    wr(8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_misc;
    rd(8'h28, rv); chk("R13 unmapped read", rv, 0);
    wr(8'h04, 32'h0000_0003);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h00, rv); chk("R13 read-only writes", rv, 32'h3);
    rd(8'h24, rv); chk("R13 pend untouched", rv, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_dir();
    t_out();
    t_pinval();
    t_cfg();
    t_rise_sticky();
    t_both_fall();
    t_level();
    t_mask();
    t_upper();
    t_race();
    t_misc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule